// File: doc/BRIEF.md
# Sliding-Window Token Call Sequencer

This block is the fetch and dispatch engine of a token-threaded processor. Code is a stream of fixed-width tokens in a code memory. A separate target table memory holds 32-bit entries, and each entry carries one extra flag bit. The token does not contain a call address. Instead, it is an index into a window of the target table. The window's base is derived from the program counter, so the same token value reaches different targets in different parts of the code.

Each token is classified as one of four kinds:

- A return token, which pops the internal return stack.
- A linear-instruction token, which is handed to an external decoder with a one-cycle strobe.
- A literal, which is a table entry with its flag set and is copied into a literal register.
- A call, which pushes the return address and jumps to the table entry.

Both memories are synchronous with one cycle of read latency. The block only ever reads the target table, and it has no path that writes it.

Top module: `token_seq`

## Requirements
- R1: After synchronous reset:
  - `pc` equals START_ADDR (default 0x0040).
  - Both stack flags are low.
  - `litValue` is 0 and `linStrobe` is low.
  - The return stack is empty.
- R2: `codeAddr` always shows `pc`. The token returned one cycle later is decoded, and any token other than a valid return moves `pc` one location past that token.
- R3: The table address for a token at code address A is ((A+1) >> WIN_SHIFT) + token, with WIN_SHIFT defaulting to 4. A token at 0x4E therefore uses base 4, and a token at 0x4F uses base 5.
- R4: Tokens 1 to 255 are calls when their table entry has bit 32 clear:
  - The address A+1 is pushed.
  - `pc` is loaded from entry bits [ADDR_W-1:0].
  - A call takes three clock cycles.
- R5: Token value 0 is a return. It loads `pc` with the most recently pushed address (last in, first out) and takes two clock cycles.
- R6: Tokens at or above 2^TOKEN_W - LIN_COUNT (256 to 511 by default) are linear instructions:
  - `linStrobe` is high for exactly one cycle while `linToken` shows the token.
  - `pc` advances by one after two cycles.
  - No table entry is consulted. Token 255 is still a call.
- R7: A table entry with bit 32 set is a literal:
  - Bits [31:0] go to `litValue`.
  - `pc` continues at A+1.
  - Nothing is pushed.
- R8: The return stack holds 16 addresses. A call made while it is full does not push or jump; it sets a sticky `stackOverflow` flag and continues at A+1.
- R9: A return made while the stack is empty sets a sticky `stackUnderflow` flag and continues at A+1.
- R10: A reset applied in the middle of a run clears both sticky flags and restarts fetching at START_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| codeAddr | output | ADDR_W | Code memory read address |
| codeData | input | TOKEN_W | Token read from code memory, one cycle after the address |
| tblAddr | output | ADDR_W | Target table read address |
| tblData | input | 33 | Table entry: bit 32 is the literal flag, bits 31:0 are the value |
| litValue | output | 32 | Literal register |
| linStrobe | output | 1 | One-cycle handoff pulse for the linear decoder |
| linToken | output | TOKEN_W | Token being handed off |
| stackOverflow | output | 1 | Sticky flag: call attempted with a full stack |
| stackUnderflow | output | 1 | Sticky flag: return attempted with an empty stack |
| pc | output | ADDR_W | Program counter |

## Verification
The embedded assertions check the following on every cycle:
- The sequencing of the three-step call.
- The return always finishing in two cycles.
- The stickiness of both error flags.
- A full stack refusing to grow.
- An empty stack staying empty on a pop.
- A literal leaving `pc` untouched.
- The one-cycle width of the decoder strobe.

Only the directed scenarios show end-to-end behaviour against independently computed values:
- The window base shifting at a 16-location boundary.
- Nested call and return order.
- The exact 16-entry depth of the stack.
- The split between call tokens and linear tokens at 255/256.
- Literal values reaching the output.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_TABLE  = 2'd2
  } seqState_t;

  // strobes from control to datapath and stack
  typedef struct packed {
    logic latchTok;
    logic pcInc;
    logic pcPop;
    logic pcTarget;
    logic loadLit;
    logic fireLin;
    logic push;
    logic pop;
  } seqCtl_t;
endpackage

// File: rtl/tsq_stack.sv
module tsq_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full,
  output logic         overflow,
  output logic         underflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] topIdx;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign topIdx = count - CNT_W'(1);
  assign top    = mem[topIdx[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push) begin
        if (full) overflow <= 1'b1;
        else begin
          mem[count[PTR_W-1:0]] <= din;
          count <= count + CNT_W'(1);
        end
      end else if (pop) begin
        if (empty) underflow <= 1'b1;
        else count <= count - CNT_W'(1);
      end
    end
  end

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_full_no_grow_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> $stable(count));
  assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> empty);
endmodule

// File: rtl/tsq_ctrl.sv
module tsq_ctrl
  import tsq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    isRet,
  input  logic    isLin,
  input  logic    entryIsLit,
  input  logic    stackEmpty,
  input  logic    stackFull,
  output seqCtl_t ctl
);
  seqState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_FETCH: stateNext = ST_DECODE;
      ST_DECODE: begin
        ctl.latchTok = 1'b1;
        if (isRet) begin
          ctl.pop = 1'b1;
          if (stackEmpty) ctl.pcInc = 1'b1;
          else            ctl.pcPop = 1'b1;
          stateNext = ST_FETCH;
        end else if (isLin) begin
          ctl.fireLin = 1'b1;
          ctl.pcInc   = 1'b1;
          stateNext   = ST_FETCH;
        end else begin
          ctl.pcInc = 1'b1;
          stateNext = ST_TABLE;
        end
      end
      ST_TABLE: begin
        if (entryIsLit) ctl.loadLit = 1'b1;
        else begin
          ctl.push = 1'b1;
          if (!stackFull) ctl.pcTarget = 1'b1;
        end
        stateNext = ST_FETCH;
      end
      default: stateNext = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= stateNext;
  end

  assert_table_after_decode_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TABLE) |-> ($past(state) == ST_DECODE));
  assert_call_three_cycles_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TABLE) |=> (state == ST_FETCH));
  assert_return_two_cycles_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && isRet) |=> (state == ST_FETCH));
endmodule

// File: rtl/tsq_datapath.sv
module tsq_datapath
  import tsq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          TOKEN_W    = 9,
  parameter int          WIN_SHIFT  = 4,
  parameter int          LIN_COUNT  = 256,
  parameter logic [15:0] START_ADDR = 16'h0040
) (
  input  logic               clk,
  input  logic               rst,
  input  seqCtl_t            ctl,
  input  logic [TOKEN_W-1:0] codeData,
  input  logic [32:0]        tblData,
  input  logic [ADDR_W-1:0]  stackTop,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  tblAddr,
  output logic               isRet,
  output logic               isLin,
  output logic               entryIsLit,
  output logic [31:0]        litValue,
  output logic               linStrobe,
  output logic [TOKEN_W-1:0] linToken
);
  localparam int LIN_BASE = (1 << TOKEN_W) - LIN_COUNT;

  logic [ADDR_W-1:0]  nextPc;
  logic [ADDR_W-1:0]  winBase;
  logic [TOKEN_W-1:0] q;

  assign nextPc     = pc + ADDR_W'(1);
  assign winBase    = nextPc >> WIN_SHIFT;
  assign tblAddr    = winBase + ADDR_W'(codeData);
  assign isRet      = (codeData == '0);
  assign entryIsLit = tblData[32];
  assign linToken   = q;

  generate
    if (LIN_COUNT == 0) begin : gNoLin
      assign isLin = 1'b0;
    end else begin : gLin
      assign isLin = (codeData >= TOKEN_W'(LIN_BASE));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= ADDR_W'(START_ADDR);
      q         <= '0;
      litValue  <= '0;
      linStrobe <= 1'b0;
    end else begin
      linStrobe <= ctl.fireLin;
      if (ctl.latchTok) q <= codeData;
      if (ctl.pcInc)         pc <= nextPc;
      else if (ctl.pcPop)    pc <= stackTop;
      else if (ctl.pcTarget) pc <= tblData[ADDR_W-1:0];
      if (ctl.loadLit) litValue <= tblData[31:0];
    end
  end

  assert_lit_keeps_pc_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.loadLit |=> $stable(pc));
  assert_lin_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    linStrobe |=> !linStrobe);
endmodule

// File: rtl/token_seq.sv
module token_seq
  import tsq_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          TOKEN_W     = 9,
  parameter int          WIN_SHIFT   = 4,
  parameter int          LIN_COUNT   = 256,
  parameter int          STACK_DEPTH = 16,
  parameter logic [15:0] START_ADDR  = 16'h0040
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  codeAddr,
  input  logic [TOKEN_W-1:0] codeData,
  output logic [ADDR_W-1:0]  tblAddr,
  input  logic [32:0]        tblData,
  output logic [31:0]        litValue,
  output logic               linStrobe,
  output logic [TOKEN_W-1:0] linToken,
  output logic               stackOverflow,
  output logic               stackUnderflow,
  output logic [ADDR_W-1:0]  pc
);
  seqCtl_t           ctl;
  logic              isRet, isLin, entryIsLit;
  logic              stackEmpty, stackFull;
  logic [ADDR_W-1:0] stackTop;

  assign codeAddr = pc;

  tsq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .isRet      (isRet),
    .isLin      (isLin),
    .entryIsLit (entryIsLit),
    .stackEmpty (stackEmpty),
    .stackFull  (stackFull),
    .ctl        (ctl)
  );

  tsq_datapath #(
    .ADDR_W     (ADDR_W),
    .TOKEN_W    (TOKEN_W),
    .WIN_SHIFT  (WIN_SHIFT),
    .LIN_COUNT  (LIN_COUNT),
    .START_ADDR (START_ADDR)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .codeData   (codeData),
    .tblData    (tblData),
    .stackTop   (stackTop),
    .pc         (pc),
    .tblAddr    (tblAddr),
    .isRet      (isRet),
    .isLin      (isLin),
    .entryIsLit (entryIsLit),
    .litValue   (litValue),
    .linStrobe  (linStrobe),
    .linToken   (linToken)
  );

  tsq_stack #(
    .DEPTH (STACK_DEPTH),
    .W     (ADDR_W)
  ) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (ctl.push),
    .pop       (ctl.pop),
    .din       (pc),
    .top       (stackTop),
    .empty     (stackEmpty),
    .full      (stackFull),
    .overflow  (stackOverflow),
    .underflow (stackUnderflow)
  );
endmodule

// File: tb/tb_token_seq.sv
`timescale 1ns/1ps
module tb_token_seq;
  localparam int AW = 16;
  localparam int TW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] codeAddr, tblAddr, pc;
  logic [TW-1:0] codeData, linToken;
  logic [32:0]   tblData;
  logic [31:0]   litValue;
  logic          linStrobe, stackOverflow, stackUnderflow;

  logic [TW-1:0] codeMem [1024];
  logic [32:0]   tblMem  [1024];

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  token_seq dut (
    .clk(clk), .rst(rst), .codeAddr(codeAddr), .codeData(codeData),
    .tblAddr(tblAddr), .tblData(tblData), .litValue(litValue),
    .linStrobe(linStrobe), .linToken(linToken), .stackOverflow(stackOverflow),
    .stackUnderflow(stackUnderflow), .pc(pc)
  );

  always @(posedge clk) begin
    codeData <= codeMem[codeAddr[9:0]];
    tblData  <= tblMem[tblAddr[9:0]];
  end

  function automatic int winIdx(input int tokAddr, input int tok);
    return ((tokAddr + 1) >> 4) + tok;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic holdReset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      codeMem[i] = '0;
      tblMem[i]  = '0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic release_();
    rst = 1'b0;
  endtask

  task automatic testReset();
    holdReset();
    check("R1 pc", pc, 16'h0040);
    check("R1 overflow", stackOverflow, 0);
    check("R1 underflow", stackUnderflow, 0);
    check("R1 litValue", litValue, 0);
    check("R1 linStrobe", linStrobe, 0);
    check("R2 codeAddr follows pc", codeAddr, 16'h0040);
  endtask

  task automatic testCallReturn();
    holdReset();
    codeMem[16'h40] = 9'd3;
    tblMem[winIdx(16'h40, 3)] = {1'b0, 32'h0000_0080};
    codeMem[16'h80] = 9'd0;
    release_();
    step(3);
    check("R4 call target", pc, 16'h0080);
    step(2);
    check("R5 return address", pc, 16'h0041);
    check("R9 no underflow on valid return", stackUnderflow, 0);
  endtask

  task automatic testWindowSlide();
    holdReset();
    codeMem[16'h40] = 9'd2;
    tblMem[winIdx(16'h40, 2)] = {1'b0, 32'h0000_004E};
    codeMem[16'h4E] = 9'd3;
    tblMem[winIdx(16'h4E, 3)] = {1'b0, 32'h0000_0090};
    codeMem[16'h90] = 9'd0;
    codeMem[16'h4F] = 9'd3;
    tblMem[winIdx(16'h4F, 3)] = {1'b0, 32'h0000_00A0};
    release_();
    step(6);
    check("R3 base 4 before boundary", pc, 16'h0090);
    step(2);
    check("R5 nested return LIFO", pc, 16'h004F);
    step(3);
    check("R3 base 5 after boundary", pc, 16'h00A0);
  endtask

  task automatic testLiteralUnderflow();
    holdReset();
    codeMem[16'h40] = 9'd5;
    tblMem[winIdx(16'h40, 5)] = {1'b1, 32'hDEAD_BEEF};
    codeMem[16'h41] = 9'd0;
    release_();
    step(3);
    check("R7 literal value", litValue, 32'hDEAD_BEEF);
    check("R7 pc continues", pc, 16'h0041);
    step(2);
    check("R7 nothing pushed -> R9 underflow", stackUnderflow, 1);
    check("R9 pc continues after underflow", pc, 16'h0042);
  endtask

  task automatic testLinear();
    holdReset();
    codeMem[16'h40] = 9'h1A5;
    tblMem[winIdx(16'h40, 9'h1A5)] = {1'b1, 32'h1234_5678};
    codeMem[16'h41] = 9'h0FF;
    tblMem[winIdx(16'h41, 9'h0FF)] = {1'b0, 32'h0000_0200};
    release_();
    step(2);
    check("R6 strobe high", linStrobe, 1);
    check("R6 token handed off", linToken, 9'h1A5);
    check("R6 pc advanced", pc, 16'h0041);
    step(1);
    check("R6 strobe one cycle", linStrobe, 0);
    step(2);
    check("R6 token 255 is a call", pc, 16'h0200);
    check("R6 table not consulted", litValue, 0);
  endtask

  task automatic testOverflow();
    holdReset();
    codeMem[16'h40] = 9'd1;
    tblMem[winIdx(16'h40, 1)] = {1'b0, 32'h0000_0040};
    codeMem[16'h41] = 9'd0;
    release_();
    step(48);
    check("R8 sixteen calls fit", stackOverflow, 0);
    check("R8 pc after 16 calls", pc, 16'h0040);
    step(3);
    check("R8 overflow raised", stackOverflow, 1);
    check("R8 pc continues", pc, 16'h0041);
    step(32);
    check("R8 sixteen entries popped", stackUnderflow, 0);
    check("R8 pc after pops", pc, 16'h0041);
    step(2);
    check("R9 underflow after depth", stackUnderflow, 1);
    check("R8 overflow sticky", stackOverflow, 1);
    @(negedge clk);
    rst = 1'b1;
    step(1);
    check("R10 overflow cleared", stackOverflow, 0);
    check("R10 underflow cleared", stackUnderflow, 0);
    check("R10 pc restart", pc, 16'h0040);
    rst = 1'b0;
  endtask

  initial begin
    testReset();
    testCallReturn();
    testWindowSlide();
    testLiteralUnderflow();
    testLinear();
    testOverflow();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule